// File: doc/BRIEF.md
# Iterative Element Integer Divider

This block divides one integer element by one scalar and returns either the quotient or the remainder. The operands may be read as unsigned or as two's-complement signed values. A two-bit field selects the element width, which is 8, 16, 32 or 64 bits. Only the low element-width bits of each operand take part. The result is written into the low element-width bits of the output, and the bits above it are zero.

Division is truncating, so both quotient and remainder round toward zero. The design uses a restoring shift-subtract loop that produces one quotient bit per clock. Signed operands are turned into magnitudes before the loop, and the signs are applied again afterwards. Two cases never raise a trap. A zero divisor and signed overflow (the most negative value divided by minus one) each give a fixed result. A zero divisor is found when the operation is accepted, and it finishes at once without running the loop.

A host pulses `start` while `busy` is low and waits for the single-cycle `done` pulse. The result is held on `result` until the next completion.

Top module: `elemdiv_unit`

## Requirements
- R1: `op` encoding: 00 unsigned quotient, 01 signed quotient, 10 unsigned remainder, 11 signed remainder. `ew` encoding: 00 = 8, 01 = 16, 10 = 32, 11 = 64 bits. Operand bits above the element width are ignored, and result bits above it are zero.
- R2: Unsigned quotient and remainder are truncating: a = q*b + r with 0 <= r < b.
- R3: The signed quotient is rounded toward zero, for example -100/7 gives -14.
- R4: The signed remainder has the sign of the dividend, and its magnitude is smaller than the divisor's: -100 rem 7 gives -2, and 100 rem -7 gives 2.
- R5: A quotient, signed or unsigned, with a zero divisor returns all ones in the element width.
- R6: A remainder, signed or unsigned, with a zero divisor returns the dividend's low element-width bits unchanged.
- R7: A signed quotient of the most negative element value divided by minus one returns the most negative value. The matching signed remainder returns zero.
- R8: Take the clock edge at which an accepted `start` is sampled. With a zero divisor, `done` is high for one cycle right after that edge. Otherwise `done` rises at the (W+1)-th edge after it, where W is the element width.
- R9: `busy` is high from the edge that accepts a non-zero-divisor start until `done` rises. It is low in the `done` cycle. A `start` seen while `busy` is high is ignored, and a `start` in the `done` cycle is accepted.
- R10: After reset `busy` and `done` are low and `result` is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a division when busy is low |
| op | input | 2 | Operation select (see R1) |
| ew | input | 2 | Element width select (see R1) |
| dividend | input | DATA_W (64) | Vector element operand |
| divisor | input | DATA_W (64) | Scalar operand |
| busy | output | 1 | Division in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | DATA_W (64) | Quotient or remainder, zero-extended |

## Verification
Two functions can share a cycle. One is completing an earlier division. The other is deciding whether a new `start` is accepted or dropped. The bench asserts `start` in the very cycle it observes `done`, using a zero divisor, and expects a second `done` on the next cycle carrying the new dividend. It also pulses a zero-divisor `start` in the middle of a 64-bit division and expects no early `done`, an unchanged final result and an unchanged latency.

// File: rtl/elemdiv_pkg.sv
package elemdiv_pkg;

   typedef enum logic [1:0] {
      OP_QUO_U = 2'b00,
      OP_QUO_S = 2'b01,
      OP_REM_U = 2'b10,
      OP_REM_S = 2'b11
   } div_op_e;

   localparam int unsigned NUM_EW  = 4;
   localparam int unsigned MIN_EW  = 8;
   localparam int unsigned WIDEST  = MIN_EW << (NUM_EW - 1);

   function automatic int unsigned ew_bits(input logic [1:0] sel);
      return MIN_EW << sel;
   endfunction

endpackage

// File: rtl/elemdiv_prep.sv
module elemdiv_prep
   import elemdiv_pkg::*;
#(
   parameter int unsigned DATA_W = 64,
   parameter int unsigned CW     = $clog2(DATA_W + 1)
) (
   input  logic [1:0]        op,
   input  logic [1:0]        ew,
   input  logic [DATA_W-1:0] a_in,
   input  logic [DATA_W-1:0] b_in,
   output logic [DATA_W-1:0] elem_mask,
   output logic [CW-1:0]     steps,
   output logic [DATA_W-1:0] num_aligned,
   output logic [DATA_W-1:0] den_mag,
   output logic              flip_quo,
   output logic              flip_rem,
   output logic              den_zero,
   output logic [DATA_W-1:0] zero_res
);

   logic [DATA_W-1:0] lane_mask [NUM_EW];

   for (genvar g = 0; g < NUM_EW; g++) begin : g_lane
      localparam int unsigned LW = MIN_EW << g;
      if (LW >= DATA_W) begin : g_full
         assign lane_mask[g] = '1;
      end else begin : g_part
         assign lane_mask[g] = {{(DATA_W - LW){1'b0}}, {LW{1'b1}}};
      end
   end

   logic [DATA_W-1:0] sign_bit, a_m, b_m, a_mag;
   logic              is_signed, is_rem, a_neg, b_neg;
   logic [CW-1:0]     align;

   always_comb begin
      elem_mask = lane_mask[ew];
      sign_bit  = elem_mask ^ (elem_mask >> 1);
      is_signed = op[0];
      is_rem    = op[1];
      a_m       = a_in & elem_mask;
      b_m       = b_in & elem_mask;
      a_neg     = is_signed && ((a_m & sign_bit) != '0);
      b_neg     = is_signed && ((b_m & sign_bit) != '0);
      a_mag     = a_neg ? ((~a_m + 1'b1) & elem_mask) : a_m;
      den_mag   = b_neg ? ((~b_m + 1'b1) & elem_mask) : b_m;
      steps     = CW'(ew_bits(ew));
      align     = CW'(DATA_W) - steps;
      num_aligned = a_mag << align;
      flip_quo  = a_neg ^ b_neg;
      flip_rem  = a_neg;
      den_zero  = (b_m == '0);
      zero_res  = is_rem ? a_m : elem_mask;
   end

endmodule

// File: rtl/elemdiv_iter.sv
module elemdiv_iter #(
   parameter int unsigned DATA_W = 64,
   parameter int unsigned CW     = $clog2(DATA_W + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [DATA_W-1:0] num,
   input  logic [DATA_W-1:0] den,
   input  logic [CW-1:0]     steps,
   output logic              fin,
   output logic [DATA_W-1:0] quo,
   output logic [DATA_W-1:0] rem
);

   logic [DATA_W-1:0] quo_q, rem_q, den_q;
   logic [CW-1:0]     cnt;
   logic              run, fin_q;
   logic [DATA_W:0]   trial, diff;
   logic              ge;

   always_comb begin
      trial = {rem_q, quo_q[DATA_W-1]};
      diff  = trial - {1'b0, den_q};
      ge    = (trial >= {1'b0, den_q});
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         quo_q <= '0;
         rem_q <= '0;
         den_q <= '0;
         cnt   <= '0;
         run   <= 1'b0;
         fin_q <= 1'b0;
      end else begin
         fin_q <= 1'b0;
         if (load) begin
            quo_q <= num;
            rem_q <= '0;
            den_q <= den;
            cnt   <= steps;
            run   <= 1'b1;
         end else if (run) begin
            quo_q <= {quo_q[DATA_W-2:0], ge};
            rem_q <= ge ? diff[DATA_W-1:0] : trial[DATA_W-1:0];
            cnt   <= cnt - 1'b1;
            if (cnt == CW'(1)) begin
               run   <= 1'b0;
               fin_q <= 1'b1;
            end
         end
      end
   end

   assign fin = fin_q;
   assign quo = quo_q;
   assign rem = rem_q;

   // R8: one step per cycle while iterating
   a_r8_count_step: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !load) |=> (cnt == $past(cnt) - CW'(1)));

   // R2: a finished restoring pass leaves the remainder below the divisor
   a_r2_rem_below_den: assert property (@(posedge clk) disable iff (!rst_n)
      fin_q |-> (rem_q < den_q));

endmodule

// File: rtl/elemdiv_fix.sv
module elemdiv_fix #(
   parameter int unsigned DATA_W = 64
) (
   input  logic [DATA_W-1:0] quo_raw,
   input  logic [DATA_W-1:0] rem_raw,
   input  logic [DATA_W-1:0] elem_mask,
   input  logic              flip_quo,
   input  logic              flip_rem,
   input  logic              want_rem,
   output logic [DATA_W-1:0] value
);

   logic [DATA_W-1:0] q_m, r_m, q_s, r_s;

   always_comb begin
      q_m   = quo_raw & elem_mask;
      r_m   = rem_raw & elem_mask;
      q_s   = flip_quo ? ((~q_m + 1'b1) & elem_mask) : q_m;
      r_s   = flip_rem ? ((~r_m + 1'b1) & elem_mask) : r_m;
      value = want_rem ? r_s : q_s;
   end

endmodule

// File: rtl/elemdiv_unit.sv
module elemdiv_unit
   import elemdiv_pkg::*;
#(
   parameter int unsigned DATA_W = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [1:0]        op,
   input  logic [1:0]        ew,
   input  logic [DATA_W-1:0] dividend,
   input  logic [DATA_W-1:0] divisor,
   output logic              busy,
   output logic              done,
   output logic [DATA_W-1:0] result
);

   localparam int unsigned CW = $clog2(DATA_W + 1);

   initial begin
      assert (DATA_W >= WIDEST)
         else $error("DATA_W must hold the widest element");
   end

   logic [DATA_W-1:0] elem_mask, num_aligned, den_mag, zero_res;
   logic [CW-1:0]     steps;
   logic              flip_quo, flip_rem, den_zero;

   elemdiv_prep #(.DATA_W(DATA_W), .CW(CW)) u_prep (
      .op          (op),
      .ew          (ew),
      .a_in        (dividend),
      .b_in        (divisor),
      .elem_mask   (elem_mask),
      .steps       (steps),
      .num_aligned (num_aligned),
      .den_mag     (den_mag),
      .flip_quo    (flip_quo),
      .flip_rem    (flip_rem),
      .den_zero    (den_zero),
      .zero_res    (zero_res)
   );

   logic accept, load;
   assign accept = start && !busy;
   assign load   = accept && !den_zero;

   logic              fin;
   logic [DATA_W-1:0] quo_raw, rem_raw;

   elemdiv_iter #(.DATA_W(DATA_W), .CW(CW)) u_iter (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (load),
      .num   (num_aligned),
      .den   (den_mag),
      .steps (steps),
      .fin   (fin),
      .quo   (quo_raw),
      .rem   (rem_raw)
   );

   logic [DATA_W-1:0] mask_q;
   logic              flip_quo_q, flip_rem_q, rem_sel_q;
   logic [DATA_W-1:0] fixed;

   elemdiv_fix #(.DATA_W(DATA_W)) u_fix (
      .quo_raw   (quo_raw),
      .rem_raw   (rem_raw),
      .elem_mask (mask_q),
      .flip_quo  (flip_quo_q),
      .flip_rem  (flip_rem_q),
      .want_rem  (rem_sel_q),
      .value     (fixed)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy       <= 1'b0;
         done       <= 1'b0;
         result     <= '0;
         mask_q     <= '0;
         flip_quo_q <= 1'b0;
         flip_rem_q <= 1'b0;
         rem_sel_q  <= 1'b0;
      end else begin
         done <= 1'b0;
         if (accept) begin
            if (den_zero) begin
               result <= zero_res;
               done   <= 1'b1;
            end else begin
               busy       <= 1'b1;
               mask_q     <= elem_mask;
               flip_quo_q <= flip_quo;
               flip_rem_q <= flip_rem;
               rem_sel_q  <= op[1];
            end
         end
         if (fin) begin
            busy   <= 1'b0;
            done   <= 1'b1;
            result <= fixed;
         end
      end
   end

   // R8: a zero divisor completes on the accepting edge
   a_r8_zero_div_done: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy && den_zero) |=> (done && !busy));

   // R9: busy and done never overlap
   a_r9_busy_done_excl: assert property (@(posedge clk) disable iff (!rst_n)
      !(busy && done));

   // R9: a start during an iteration neither ends it nor completes early
   a_r9_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start && !fin) |=> (busy && !done));

   // R9: iteration completion always clears busy
   a_r9_fin_clears: assert property (@(posedge clk) disable iff (!rst_n)
      fin |=> (done && !busy));

endmodule

// File: tb/elemdiv_unit_test.sv
module elemdiv_unit_test;

   localparam int DW = 64;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic [1:0]    op = 2'b00;
   logic [1:0]    ew = 2'b00;
   logic [DW-1:0] dividend = '0;
   logic [DW-1:0] divisor = '0;
   logic          busy, done;
   logic [DW-1:0] result;

   int checks = 0;
   int fails  = 0;
   int cyc    = 0;

   elemdiv_unit #(.DATA_W(DW)) uut (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .op       (op),
      .ew       (ew),
      .dividend (dividend),
      .divisor  (divisor),
      .busy     (busy),
      .done     (done),
      .result   (result)
   );

   always #5 clk = ~clk;

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 100000) begin
         fails = fails + 1;
         $display("FAIL watchdog: run hung, actual cycles=%0d expected below 100000", cyc);
         $display("TB_RESULT checks=%0d failures=%0d", checks + 1, fails);
         $finish;
      end
   end

   // {op, ew, dividend, divisor, expected}
   localparam int NV = 18;
   localparam logic [195:0] VEC [NV] = '{
      {2'b00, 2'b00, 64'd200, 64'd7, 64'h1C},
      {2'b10, 2'b00, 64'd200, 64'd7, 64'h04},
      {2'b01, 2'b00, 64'h9C, 64'h07, 64'hF2},
      {2'b11, 2'b00, 64'h9C, 64'h07, 64'hFE},
      {2'b01, 2'b00, 64'h80, 64'hFF, 64'h80},
      {2'b11, 2'b00, 64'h80, 64'hFF, 64'h00},
      {2'b00, 2'b01, 64'h1234, 64'h0, 64'hFFFF},
      {2'b10, 2'b01, 64'h1234, 64'h0, 64'h1234},
      {2'b01, 2'b10, 64'd100, 64'hFFFF_FFF9, 64'hFFFF_FFF2},
      {2'b11, 2'b10, 64'd100, 64'hFFFF_FFF9, 64'h2},
      {2'b00, 2'b11, 64'hFFFF_FFFF_FFFF_FFFF, 64'h2, 64'h7FFF_FFFF_FFFF_FFFF},
      {2'b10, 2'b11, 64'hFFFF_FFFF_FFFF_FFFF, 64'h2, 64'h1},
      {2'b00, 2'b00, 64'hABCD_EF00_0000_0064, 64'h1234_0000_0000_0105, 64'h14},
      {2'b01, 2'b11, 64'h8000_0000_0000_0000, 64'hFFFF_FFFF_FFFF_FFFF, 64'h8000_0000_0000_0000},
      {2'b01, 2'b00, 64'h05, 64'h00, 64'hFF},
      {2'b11, 2'b00, 64'hFB, 64'h00, 64'hFB},
      {2'b00, 2'b00, 64'd3, 64'd10, 64'h0},
      {2'b10, 2'b00, 64'd3, 64'd10, 64'h3}
   };

   function automatic string tag_of(input int i);
      case (i)
         2, 3, 8:      return "R3";
         3 + 0 + 0:    return "R4";
         default: begin
            case (i)
               4, 5, 13:   return "R7";
               6, 14:      return "R5";
               7, 15:      return "R6";
               9:          return "R4";
               12:         return "R1";
               default:    return "R2";
            endcase
         end
      endcase
   endfunction

   function automatic logic [DW-1:0] mask_of(input logic [1:0] w);
      case (w)
         2'b00:   return 64'hFF;
         2'b01:   return 64'hFFFF;
         2'b10:   return 64'hFFFF_FFFF;
         default: return '1;
      endcase
   endfunction

   task automatic check(input string tag, input string what,
                        input logic [DW-1:0] act, input logic [DW-1:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   task automatic run_div(input logic [1:0] o, input logic [1:0] w,
                          input logic [DW-1:0] a, input logic [DW-1:0] b,
                          output logic [DW-1:0] res, output int lat);
      op = o; ew = w; dividend = a; divisor = b; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      lat = 1;
      while (!done && lat < 200) begin
         @(negedge clk);
         lat++;
      end
      res = result;
   endtask

   initial begin
      logic [DW-1:0] res;
      int lat;

      #1;
      // R10: reset state
      @(negedge clk);
      @(negedge clk);
      check("R10", "busy after reset", {63'd0, busy}, '0);
      check("R10", "done after reset", {63'd0, done}, '0);
      check("R10", "result after reset", result, '0);
      rst_n = 1'b1;
      @(negedge clk);

      for (int i = 0; i < NV; i++) begin
         logic [1:0] vo, vw;
         logic [DW-1:0] va, vb, ve;
         int exp_lat;
         {vo, vw, va, vb, ve} = VEC[i];
         run_div(vo, vw, va, vb, res, lat);
         check(tag_of(i), $sformatf("vector %0d result", i), res, ve);
         exp_lat = ((vb & mask_of(vw)) == '0) ? 1 : (8 << vw) + 2;
         check("R8", $sformatf("vector %0d latency", i), 64'(lat), 64'(exp_lat));
         @(negedge clk);
      end

      // R9: start during a 64-bit division is ignored
      op = 2'b00; ew = 2'b11; dividend = 64'd1000; divisor = 64'd10; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      check("R9", "busy after accepted start", {63'd0, busy}, 64'd1);
      @(negedge clk);
      @(negedge clk);
      op = 2'b10; dividend = 64'd7; divisor = 64'd0; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      check("R9", "no done from ignored start", {63'd0, done}, '0);
      check("R9", "still busy after ignored start", {63'd0, busy}, 64'd1);
      lat = 4;
      while (!done && lat < 200) begin
         @(negedge clk);
         lat++;
      end
      check("R9", "first division result kept", result, 64'd100);
      check("R8", "latency unchanged by ignored start", 64'(lat), 64'd66);
      check("R9", "busy low in done cycle", {63'd0, busy}, '0);

      // R9: start in the done cycle is accepted (zero divisor, remainder)
      op = 2'b10; ew = 2'b00; dividend = 64'd50; divisor = 64'h100; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      check("R9", "back-to-back done", {63'd0, done}, 64'd1);
      check("R6", "back-to-back zero-divisor remainder", result, 64'd50);
      @(negedge clk);
      check("R8", "done is a single pulse", {63'd0, done}, '0);

      // R1: 16-bit signed with noisy upper bits: -300 / 12 = -25
      run_div(2'b01, 2'b01, 64'hDEAD_0000_0000_FED4, 64'hFFFF_FFFF_0000_000C, res, lat);
      check("R1", "16-bit signed masked operands", res, 64'hFFE7);
      check("R8", "16-bit latency", 64'(lat), 64'd18);

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule